// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Overrun Lockout

This block receives fixed-width frames, eight bits by default, over a clock-synchronous serial link. The least significant bit arrives first. In master role it generates the transfer clock itself from a fixed divider of the system clock. In slave role it follows an external transfer clock, which it brings into the system clock domain through a two-flop synchronizer together with the data line. A completed frame is copied into a data register and raises a full flag. When enabled, a level-sensitive receive interrupt is requested.

If the previous frame has not been read when the last bit of a new frame is sampled, the block does not overwrite the data register. It latches an overrun flag instead and stops receiving. While the flag is set, the master clock is held low and slave clock edges are ignored. Software must write zero to the flag to resume. A small register interface holds the control bits, the status flags and the data register. Reading the data register clears the full flag.

Top module: `syncRxUnit`

## Requirements
- R1: After reset, the control bits, both flags and the data register read as zero, serClkOut is low and both interrupts are low.
- R2: While the enable bit (control address 0, bit 0) is 0, clock edges on the link store nothing: the full flag stays 0 and the data register is unchanged.
- R3: With enable=1, master role (control bit 3 = 1) and no overrun, serClkOut toggles every HALF_DIV system clocks and serDataIn is sampled at its rising edge. Otherwise serClkOut is held low.
- R4: In slave role (control bit 3 = 0), serDataIn is sampled at each rising edge of serClkIn, after both lines pass through a two-flop synchronizer.
- R5: The first bit sampled lands in bit 0 of the data register. After DATA_W samples the frame is stored in the data register (address 2) and the full flag (status address 1, bit 0) becomes 1.
- R6: A read of address 2 returns the data register and clears the full flag.
- R7: rxIrq equals the full flag ANDed with the receive-interrupt enable (control bit 1).
- R8: If the full flag is 1 when the last bit of a frame is sampled, the overrun flag (status bit 1) becomes 1, the data register keeps its previous frame, and the full flag stays 1.
- R9: While the overrun flag is 1, no frame is received. Writing status with bit 1 = 0 clears the flag and reception resumes. Writing bit 1 = 1 leaves the flag unchanged.
- R10: errIrq equals the overrun flag ANDed with the error-interrupt enable (control bit 2).
- R11: Clearing the enable bit discards a partial frame and restarts the bit count at zero. The full and overrun flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClkIn | input | 1 | Transfer clock input in slave role |
| serDataIn | input | 1 | Serial data input |
| serClkOut | output | 1 | Transfer clock output in master role |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address (0 control, 1 status, 2 data) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Overrun interrupt request |

## Verification
On every cycle the assertions check the following:
- The overrun flag rises only when the full flag was already set.
- The data register is frozen at that moment and for as long as the overrun lasts.
- The full flag rises only while the block is enabled.
- A read clears the full flag.
- Disabling resets the bit count and parks the master clock.

Only the bench scenarios can show the rest: the received byte value and its bit order in both roles, the master clock period, interrupt gating, the abort of a partial frame, and the full overrun sequence of a lockout, an ignored frame, a clear and then a resumed frame.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic useMaster;   // select raw data line (master) or synchronized line (slave)
    logic sampleBit;   // shift in one bit this cycle
    logic storeFrame;  // copy the completed frame into the data register
  } srxStrobes_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/srx_control.sv
module srx_control #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    serClkIn,
  input  logic                    regWrEn,
  input  logic                    regRdEn,
  input  logic [1:0]              regAddr,
  input  logic [7:0]              regWrData,
  output logic                    serClkOut,
  output srx_pkg::srxStrobes_t    strobes,
  output logic [3:0]              ctrlBits,
  output logic                    fullFlag,
  output logic                    ovrFlag,
  output logic [$clog2(DATA_W)-1:0] bitCnt,
  output logic                    rxIrq,
  output logic                    errIrq
);
  import srx_pkg::*;
  localparam int CNT_W = $clog2(DATA_W);
  localparam int DIV_W = $clog2(HALF_DIV) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(HALF_DIV - 1);

  logic rxEn, rxIrqEn, errIrqEn, masterSel;
  logic active;
  logic [DIV_W-1:0] divCnt;
  logic clkReg;
  logic [2:0] clkSync;
  logic masterRise, slaveRise, sampleNow, lastBit, overrunHit, storeNow;

  assign rxEn      = ctrlBits[0];
  assign rxIrqEn   = ctrlBits[1];
  assign errIrqEn  = ctrlBits[2];
  assign masterSel = ctrlBits[3];
  assign active    = rxEn && !ovrFlag;

  // master transfer clock divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      clkReg <= 1'b0;
    end else if (!active || !masterSel) begin
      divCnt <= '0;
      clkReg <= 1'b0;
    end else if (divCnt == DIV_END) begin
      divCnt <= '0;
      clkReg <= ~clkReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // slave clock synchronizer plus edge-detect stage
  always_ff @(posedge clk) begin
    if (!rstN) clkSync <= '0;
    else       clkSync <= {clkSync[1:0], serClkIn};
  end

  assign masterRise = active && masterSel && (divCnt == DIV_END) && !clkReg;
  assign slaveRise  = active && !masterSel && clkSync[1] && !clkSync[2];
  assign sampleNow  = masterRise || slaveRise;
  assign lastBit    = (bitCnt == LAST_BIT);
  assign storeNow   = sampleNow && lastBit && !fullFlag;
  assign overrunHit = sampleNow && lastBit && fullFlag;

  always_ff @(posedge clk) begin
    if (!rstN)          bitCnt <= '0;
    else if (!rxEn)     bitCnt <= '0;
    else if (sampleNow) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= '0;
      fullFlag <= 1'b0;
      ovrFlag  <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CTRL) ctrlBits <= regWrData[3:0];
      if (storeNow)                             fullFlag <= 1'b1;
      else if (regRdEn && regAddr == ADDR_DATA) fullFlag <= 1'b0;
      if (overrunHit)                                       ovrFlag <= 1'b1;
      else if (regWrEn && regAddr == ADDR_STAT && !regWrData[1]) ovrFlag <= 1'b0;
    end
  end

  assign strobes.useMaster  = masterSel;
  assign strobes.sampleBit  = sampleNow;
  assign strobes.storeFrame = storeNow;
  assign serClkOut = clkReg;
  assign rxIrq     = fullFlag && rxIrqEn;
  assign errIrq    = ovrFlag && errIrqEn;
endmodule

// File: rtl/srx_datapath.sv
module srx_datapath #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serDataIn,
  input  srx_pkg::srxStrobes_t strobes,
  input  logic [1:0]           regAddr,
  input  logic [3:0]           ctrlBits,
  input  logic                 fullFlag,
  input  logic                 ovrFlag,
  output logic [DATA_W-1:0]    dataReg,
  output logic [7:0]           regRdData
);
  import srx_pkg::*;
  logic [1:0] dataSync;
  logic [DATA_W-1:0] shiftReg;
  logic bitIn;

  always_ff @(posedge clk) begin
    if (!rstN) dataSync <= '0;
    else       dataSync <= {dataSync[0], serDataIn};
  end

  assign bitIn = strobes.useMaster ? serDataIn : dataSync[1];

  // first bit ends in bit 0: shift in from the top
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataReg  <= '0;
    end else begin
      if (strobes.sampleBit)  shiftReg <= {bitIn, shiftReg[DATA_W-1:1]};
      if (strobes.storeFrame) dataReg  <= {bitIn, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: regRdData = {4'b0, ctrlBits};
      ADDR_STAT: regRdData = {6'b0, ovrFlag, fullFlag};
      ADDR_DATA: regRdData = 8'(dataReg);
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/syncRxUnit.sv
module syncRxUnit #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClkIn,
  input  logic       serDataIn,
  output logic       serClkOut,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       rxIrq,
  output logic       errIrq
);
  srx_pkg::srxStrobes_t strobes;
  logic [3:0] ctrlBits;
  logic fullFlag, ovrFlag;
  logic [$clog2(DATA_W)-1:0] bitCnt;
  logic [DATA_W-1:0] dataReg;

  srx_control #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClkIn(serClkIn), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .serClkOut(serClkOut), .strobes(strobes), .ctrlBits(ctrlBits),
    .fullFlag(fullFlag), .ovrFlag(ovrFlag), .bitCnt(bitCnt),
    .rxIrq(rxIrq), .errIrq(errIrq));

  srx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .serDataIn(serDataIn), .strobes(strobes),
    .regAddr(regAddr), .ctrlBits(ctrlBits), .fullFlag(fullFlag),
    .ovrFlag(ovrFlag), .dataReg(dataReg), .regRdData(regRdData));
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEn,
  input logic              fullFlag,
  input logic              ovrFlag,
  input logic [CNT_W-1:0]  bitCnt,
  input logic [DATA_W-1:0] dataReg,
  input logic              serClkOut,
  input logic              regRdEn,
  input logic [1:0]        regAddr,
  input logic              storeFrame
);
  p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(fullFlag));
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $stable(dataReg));
  p_no_rx_in_ovr_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag |=> $stable(dataReg));
  p_full_needs_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> $past(rxEn));
  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 2'd2 && !storeFrame) |=> !fullFlag);
  p_abort_count_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> bitCnt == '0);
  p_clk_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn || ovrFlag) |=> !serClkOut);
endmodule

bind syncRxUnit srx_checker #(.DATA_W(DATA_W), .CNT_W($clog2(DATA_W))) u_chk (
  .clk(clk), .rstN(rstN), .rxEn(ctrlBits[0]), .fullFlag(fullFlag),
  .ovrFlag(ovrFlag), .bitCnt(bitCnt), .dataReg(dataReg),
  .serClkOut(serClkOut), .regRdEn(regRdEn), .regAddr(regAddr),
  .storeFrame(strobes.storeFrame));

// File: tb/test_syncRxUnit.sv
module test_syncRxUnit;
  localparam int HALF_DIV = 4;
  logic clk = 0, rstN = 0;
  logic serClkIn = 0, serDataIn = 0, regWrEn = 0, regRdEn = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWrData = 0;
  logic serClkOut, rxIrq, errIrq;
  logic [7:0] regRdData;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  syncRxUnit #(.DATA_W(8), .HALF_DIV(HALF_DIV)) i_syncRxUnit (
    .clk(clk), .rstN(rstN), .serClkIn(serClkIn), .serDataIn(serDataIn),
    .serClkOut(serClkOut), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rxIrq(rxIrq), .errIrq(errIrq));

  function automatic logic [7:0] ctrlWord(bit mstr, bit errEn, bit rxEn, bit en);
    return {4'b0, mstr, errEn, rxEn, en};
  endfunction
  function automatic logic expIrq(logic flag, logic enBit);
    return flag & enBit;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] v);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = v;
    @(negedge clk); regWrEn = 0;
  endtask
  task automatic readReg(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); regRdEn = 1; regAddr = a; #1 v = regRdData;
    @(negedge clk); regRdEn = 0;
  endtask
  task automatic peekReg(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; #1 v = regRdData;
  endtask

  task automatic sendSlave(logic [7:0] b, int nBits);
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk); serDataIn = b[i];
      repeat (3) @(negedge clk); serClkIn = 1;
      repeat (4) @(negedge clk); serClkIn = 0;
    end
    repeat (6) @(negedge clk);
  endtask

  // runs one master frame, then disables while keeping the enables
  task automatic sendMaster(logic [7:0] b, bit errEn, bit rxEn);
    serDataIn = b[0];
    writeReg(2'd0, ctrlWord(1, errEn, rxEn, 1));
    for (int k = 1; k < 8; k++) begin
      @(negedge serClkOut); serDataIn = b[k];
    end
    @(posedge serClkOut);
    @(negedge clk);
    writeReg(2'd0, ctrlWord(1, errEn, rxEn, 0));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    time t0, t1;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    peekReg(2'd0, v); chk("R1 ctrl", v, 0);
    peekReg(2'd1, v); chk("R1 status", v, 0);
    peekReg(2'd2, v); chk("R1 data", v, 0);
    chk("R1 clk/irq", {serClkOut, rxIrq, errIrq}, 0);

    // R2 disabled: slave frame ignored
    writeReg(2'd0, ctrlWord(0, 0, 1, 0));
    sendSlave(8'hA5, 8);
    peekReg(2'd1, v); chk("R2 full stays 0", v, 0);
    peekReg(2'd2, v); chk("R2 data unchanged", v, 0);

    // R4/R5/R7 slave frame, LSB first
    writeReg(2'd0, ctrlWord(0, 0, 1, 1));
    sendSlave(8'h3C, 8);
    peekReg(2'd1, v); chk("R5 full set", v, 8'h01);
    chk("R7 rxIrq on", rxIrq, expIrq(1, 1));
    readReg(2'd2, v); chk("R4 R5 slave data", v, 8'h3C);
    peekReg(2'd1, v); chk("R6 full cleared", v, 0);
    chk("R7 rxIrq off", rxIrq, 0);

    // R11 abort partial frame, then a clean frame
    sendSlave(8'hFF, 3);
    writeReg(2'd0, ctrlWord(0, 0, 1, 0));
    writeReg(2'd0, ctrlWord(0, 0, 1, 1));
    sendSlave(8'h81, 8);
    readReg(2'd2, v); chk("R11 aligned after abort", v, 8'h81);

    // R8/R9/R10 overrun sequence in slave role
    writeReg(2'd0, ctrlWord(0, 1, 0, 1));
    sendSlave(8'h11, 8);
    chk("R7 rxIrq masked", rxIrq, expIrq(1, 0));
    sendSlave(8'h22, 8);
    peekReg(2'd1, v); chk("R8 overrun set, full kept", v, 8'h03);
    chk("R10 errIrq", errIrq, expIrq(1, 1));
    sendSlave(8'h33, 8);
    readReg(2'd2, v); chk("R8 data keeps old frame", v, 8'h11);
    sendSlave(8'h44, 8);
    peekReg(2'd1, v); chk("R9 no rx during overrun", v, 8'h02);
    writeReg(2'd1, 8'h02);
    peekReg(2'd1, v); chk("R9 write 1 keeps flag", v, 8'h02);
    writeReg(2'd1, 8'h00);
    peekReg(2'd1, v); chk("R9 cleared", v, 0);
    chk("R10 errIrq off", errIrq, 0);
    sendSlave(8'h55, 8);
    readReg(2'd2, v); chk("R9 resumed", v, 8'h55);

    // R3 master clock period and frame
    serDataIn = 0;
    writeReg(2'd0, ctrlWord(1, 0, 0, 1));
    @(posedge serClkOut); t0 = $time;
    @(posedge serClkOut); t1 = $time;
    chk("R3 master period", 32'(t1 - t0), 32'(2 * HALF_DIV * 20));
    writeReg(2'd0, ctrlWord(1, 0, 0, 0));
    repeat (2) @(negedge clk);
    chk("R3 idle when disabled", serClkOut, 0);
    sendMaster(8'hC6, 1, 1);
    peekReg(2'd1, v); chk("R11 flags kept after disable", v, 8'h01);
    readReg(2'd2, v); chk("R3 R5 master data", v, 8'hC6);

    // R3 master overrun stops clock
    sendMaster(8'h0F, 1, 0);
    serDataIn = 0;
    writeReg(2'd0, ctrlWord(1, 1, 0, 1));
    repeat (8 * 2 * HALF_DIV + 4) @(negedge clk);
    peekReg(2'd1, v); chk("R8 master overrun", v, 8'h03);
    begin
      int highs = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); if (serClkOut) highs++;
      end
      chk("R3 clock held in overrun", highs, 0);
    end
    writeReg(2'd0, ctrlWord(1, 1, 0, 0));
    writeReg(2'd1, 8'h00);
    readReg(2'd2, v); chk("R8 master data kept", v, 8'h0F);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [7:0] b;
      bit mstr, ie;
      b = 8'($urandom);
      mstr = 1'($urandom);
      ie = 1'($urandom);
      if (mstr) sendMaster(b, 0, ie);
      else begin
        writeReg(2'd0, ctrlWord(0, 0, ie, 1));
        sendSlave(b, 8);
      end
      chk("R7 random irq", rxIrq, expIrq(1, ie));
      readReg(2'd2, v); chk("R5 random data", v, b);
      peekReg(2'd1, v); chk("R6 random clear", v, 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule